// File: doc/BRIEF.md
# Single-Precision Floating-Point Compare Unit

This block takes two IEEE-754 binary32 operands, A and B, and reports how they relate. The relation comes back as a one-hot mask in the low bits of a 32-bit result word. The same word carries one flag per operand that marks a subnormal input. The unit also drives an invalid-operation flag and a summary exception flag, which an external status unit consumes.

Subnormal operands are not flushed to zero. They are ordered by their exact values, so the smallest positive subnormal ranks above zero. The comparison is quiet: only a signalling NaN raises the invalid flag.

The logic is combinational from the operand inputs. A parameter can place a register on the outputs. A valid bit travels alongside the data.

Top module: `fcmp_unit`

## Requirements
- R1: When `out_valid` is high, exactly one of `result[3:0]` is set. Bit 0 means A<B, bit 1 means A==B, bit 2 means A>B, and bit 3 means unordered.
- R2: `result[4]` is 1 exactly when A is subnormal, meaning exponent field 0 and fraction field nonzero. `result[5]` is the same indicator for B.
- R3: Subnormal operands are compared by their exact values and are never treated as zero. For example, 0x00000001 > 0x00000000, and 0x00000001 < 0x00000002.
- R4: A quiet NaN on either input gives unordered and leaves the invalid flag clear. A quiet NaN has an all-ones exponent and fraction bit 22 set.
- R5: A signalling NaN on either input gives unordered and sets `flag_invalid`. A signalling NaN has an all-ones exponent, fraction bit 22 clear and a nonzero fraction.
- R6: +0 and -0 compare equal, in either order.
- R7: `result[31:6]` is always zero.
- R8: Ordered operands follow sign-magnitude rules. Any positive value is greater than any negative value. When both operands are negative, the one with the larger magnitude is the smaller value. Infinities rank beyond every finite value of the same sign.
- R9: `flag_summary` is 1 when any exception is raised and 0 otherwise, so an exception-free compare reports the summary flag cleared.
- R10: With `OUT_REG`=1, `out_valid`, `result` and the flags appear one clock after the inputs are presented. With `OUT_REG`=0 they follow the inputs in the same cycle.
- R11: While reset is asserted, the registered outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands on `op_a`/`op_b` are valid |
| op_a | input | 32 | Operand A, binary32 |
| op_b | input | 32 | Operand B, binary32 |
| out_valid | output | 1 | Result and flags are valid |
| result | output | 32 | Relation mask [3:0] and subnormal flags [5:4] |
| flag_invalid | output | 1 | Invalid-operation exception |
| flag_summary | output | 1 | Any exception raised by this compare |

## Verification
The clocked assertions assume that reset is applied before the first operand and that `in_valid` is never X once reset is released. The bench drives every input to a known value from time zero and changes inputs only on the falling edge. The assertions make no assumption about operand values. Any bit pattern, including every NaN and subnormal encoding, is legal input. The stimulus therefore mixes hand-picked encoding corners with pseudo-random words.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

   typedef struct packed {
      logic is_zero;
      logic is_sub;
      logic is_inf;
      logic is_qnan;
      logic is_snan;
   } fp_class_t;

   typedef enum logic [1:0] {
      REL_LT = 2'd0,
      REL_EQ = 2'd1,
      REL_GT = 2'd2,
      REL_UN = 2'd3
   } rel_e;

   localparam int unsigned SUB_A_BIT = 4;
   localparam int unsigned SUB_B_BIT = 5;

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
   import fcmp_pkg::*;
#(
   parameter int unsigned EXP_W = 8,
   parameter int unsigned MAN_W = 23,
   localparam int unsigned DATA_W = 1 + EXP_W + MAN_W,
   localparam int unsigned MAG_W  = EXP_W + MAN_W
) (
   input  logic [DATA_W-1:0] op,
   output fp_class_t         cls,
   output logic              sign,
   output logic [MAG_W-1:0]  mag
);

   logic [EXP_W-1:0] exp_f;
   logic [MAN_W-1:0] frac_f;
   logic             exp_ones, exp_none, frac_any;

   assign sign     = op[DATA_W-1];
   assign mag      = op[MAG_W-1:0];
   assign exp_f    = op[MAG_W-1 -: EXP_W];
   assign frac_f   = op[MAN_W-1:0];
   assign exp_ones = &exp_f;
   assign exp_none = ~|exp_f;
   assign frac_any = |frac_f;

   always_comb begin
      cls.is_zero = exp_none & ~frac_any;
      cls.is_sub  = exp_none &  frac_any;
      cls.is_inf  = exp_ones & ~frac_any;
      cls.is_qnan = exp_ones &  frac_f[MAN_W-1];
      cls.is_snan = exp_ones &  frac_any & ~frac_f[MAN_W-1];
   end

endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
   import fcmp_pkg::*;
#(
   parameter int unsigned MAG_W = 31
) (
   input  fp_class_t        cls_a,
   input  fp_class_t        cls_b,
   input  logic             sign_a,
   input  logic             sign_b,
   input  logic [MAG_W-1:0] mag_a,
   input  logic [MAG_W-1:0] mag_b,
   output rel_e             rel,
   output logic             invalid
);

   logic nan_a, nan_b, a_bigger;

   assign nan_a    = cls_a.is_qnan | cls_a.is_snan;
   assign nan_b    = cls_b.is_qnan | cls_b.is_snan;
   assign a_bigger = mag_a > mag_b;
   assign invalid  = cls_a.is_snan | cls_b.is_snan;

   always_comb begin
      if (nan_a || nan_b)
         rel = REL_UN;
      else if (cls_a.is_zero && cls_b.is_zero)
         rel = REL_EQ;
      else if (sign_a != sign_b)
         rel = sign_a ? REL_LT : REL_GT;
      else if (mag_a == mag_b)
         rel = REL_EQ;
      else if (a_bigger ^ sign_a)
         rel = REL_GT;
      else
         rel = REL_LT;
   end

endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit
   import fcmp_pkg::*;
#(
   parameter int unsigned EXP_W   = 8,
   parameter int unsigned MAN_W   = 23,
   parameter int unsigned RES_W   = 32,
   parameter bit          OUT_REG = 1'b1,
   localparam int unsigned DATA_W = 1 + EXP_W + MAN_W,
   localparam int unsigned MAG_W  = EXP_W + MAN_W,
   localparam int unsigned N_OPS  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   output logic              out_valid,
   output logic [RES_W-1:0]  result,
   output logic              flag_invalid,
   output logic              flag_summary
);

   if (RES_W < SUB_B_BIT + 1) begin : g_bad_res
      $error("fcmp_unit: RES_W too small for relation and subnormal bits");
   end
   if (MAN_W < 2 || EXP_W < 2) begin : g_bad_fmt
      $error("fcmp_unit: exponent and fraction need at least two bits");
   end

   logic [N_OPS-1:0][DATA_W-1:0] ops;
   fp_class_t                    cls  [N_OPS];
   logic      [N_OPS-1:0]        sgn;
   logic      [MAG_W-1:0]        mag  [N_OPS];

   assign ops[0] = op_a;
   assign ops[1] = op_b;

   for (genvar i = 0; i < N_OPS; i++) begin : g_cls
      fcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
         .op   (ops[i]),
         .cls  (cls[i]),
         .sign (sgn[i]),
         .mag  (mag[i])
      );
   end

   rel_e rel;
   logic inv_c;

   fcmp_order #(.MAG_W(MAG_W)) u_ord (
      .cls_a   (cls[0]),
      .cls_b   (cls[1]),
      .sign_a  (sgn[0]),
      .sign_b  (sgn[1]),
      .mag_a   (mag[0]),
      .mag_b   (mag[1]),
      .rel     (rel),
      .invalid (inv_c)
   );

   logic [RES_W-1:0] res_c;
   logic [0:0]       exc_vec;
   logic             sum_c;

   always_comb begin
      res_c                  = '0;
      res_c[rel]             = 1'b1;
      res_c[SUB_A_BIT]       = cls[0].is_sub;
      res_c[SUB_B_BIT]       = cls[1].is_sub;
   end

   assign exc_vec = inv_c;
   assign sum_c   = |exc_vec;

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid    <= 1'b0;
            result       <= '0;
            flag_invalid <= 1'b0;
            flag_summary <= 1'b0;
         end else begin
            out_valid    <= in_valid;
            result       <= in_valid ? res_c : '0;
            flag_invalid <= in_valid & inv_c;
            flag_summary <= in_valid & sum_c;
         end
      end

      a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);
      a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid);
      a_r5_snan_flag: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && (cls[0].is_snan || cls[1].is_snan)) |=> flag_invalid);
   end else begin : g_comb
      assign out_valid    = in_valid;
      assign result       = in_valid ? res_c : '0;
      assign flag_invalid = in_valid & inv_c;
      assign flag_summary = in_valid & sum_c;
   end

   a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $countones(result[3:0]) == 1);
   a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> result[RES_W-1:SUB_B_BIT+1] == '0);
   a_r5_invalid_unordered: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && flag_invalid) |-> result[REL_UN]);
   a_r4_nan_unordered: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (cls[0].is_qnan || cls[1].is_qnan)) |-> rel == REL_UN);
   a_r6_zero_equal: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cls[0].is_zero && cls[1].is_zero) |-> rel == REL_EQ);

endmodule

// File: tb/fcmp_unit_test.sv
module fcmp_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] op_a = '0;
   logic [31:0] op_b = '0;
   logic        out_valid;
   logic [31:0] result;
   logic        flag_invalid;
   logic        flag_summary;

   always #4 clk = ~clk;

   fcmp_unit uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .op_a(op_a), .op_b(op_b), .out_valid(out_valid),
      .result(result), .flag_invalid(flag_invalid), .flag_summary(flag_summary)
   );

   int    checks = 0;
   int    failures = 0;
   bit    finished = 1'b0;
   logic  pend_valid = 1'b0;
   logic [33:0] exp_q [$];
   string       tag_q [$];

   function automatic logic [33:0] model(logic [31:0] a, logic [31:0] b);
      bit    nan_a, nan_b, sig_a, sig_b, den_a, den_b;
      longint ka, kb;
      logic [31:0] r;
      nan_a = (a[30:23] == 8'hFF) && (a[22:0] != 0);
      nan_b = (b[30:23] == 8'hFF) && (b[22:0] != 0);
      sig_a = nan_a && !a[22];
      sig_b = nan_b && !b[22];
      den_a = (a[30:23] == 0) && (a[22:0] != 0);
      den_b = (b[30:23] == 0) && (b[22:0] != 0);
      ka = longint'(a[30:0]);
      kb = longint'(b[30:0]);
      if (a[31]) ka = -ka;
      if (b[31]) kb = -kb;
      r = 32'd0;
      if (nan_a || nan_b) r = 32'd8;
      else if (ka < kb)   r = 32'd1;
      else if (ka == kb)  r = 32'd2;
      else                r = 32'd4;
      r[4] = den_a;
      r[5] = den_b;
      return {sig_a || sig_b, sig_a || sig_b, r};
   endfunction

   task automatic check_outputs();
      logic [33:0] e;
      string       t;
      checks++;
      if (out_valid !== pend_valid) begin
         failures++;
         $display("FAIL R10 out_valid actual=%0b expected=%0b", out_valid, pend_valid);
      end
      if (pend_valid) begin
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         checks++;
         if ({flag_summary, flag_invalid, result} !== e) begin
            failures++;
            $display("FAIL %s (R1/R2/R7/R9) actual sum=%0b inv=%0b res=%h expected sum=%0b inv=%0b res=%h",
                     t, flag_summary, flag_invalid, result, e[33], e[32], e[31:0]);
         end
      end
   endtask

   task automatic step(logic v, logic [31:0] a, logic [31:0] b, string tag);
      @(negedge clk);
      check_outputs();
      in_valid = v;
      op_a = a;
      op_b = b;
      if (v) begin
         exp_q.push_back(model(a, b));
         tag_q.push_back(tag);
      end
      pend_valid = v;
   endtask

   initial begin
      logic [31:0] lfsr;
      lfsr = 32'h1234_5678;
      repeat (3) @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || result !== 32'd0 || flag_invalid !== 1'b0 || flag_summary !== 1'b0) begin
         failures++;
         $display("FAIL R11 reset actual v=%0b res=%h inv=%0b sum=%0b expected all zero",
                  out_valid, result, flag_invalid, flag_summary);
      end
      rst_n = 1'b1;
      // R1 / R8 basic ordered values
      step(1, 32'h3F800000, 32'h40000000, "R8 1<2");
      step(1, 32'h40000000, 32'h3F800000, "R8 2>1");
      step(1, 32'h3F800000, 32'h3F800000, "R1 1==1");
      step(1, 32'hBF800000, 32'hC0000000, "R8 -1>-2");
      step(1, 32'hC0000000, 32'hBF800000, "R8 -2<-1");
      step(1, 32'hBF800000, 32'h3F800000, "R8 -1<1");
      step(1, 32'hFF800000, 32'hC0000000, "R8 -inf<-2");
      step(1, 32'h7F800000, 32'h7F7FFFFF, "R8 inf>max");
      step(0, 32'h0, 32'h0, "idle");
      // R6 signed zeros
      step(1, 32'h00000000, 32'h80000000, "R6 +0==-0");
      step(1, 32'h80000000, 32'h00000000, "R6 -0==+0");
      // R2 / R3 subnormals
      step(1, 32'h00000001, 32'h00000000, "R3 den>0");
      step(1, 32'h00000001, 32'h00000002, "R3 den<den");
      step(1, 32'h80000001, 32'h00000000, "R3 -den<0");
      step(1, 32'h007FFFFF, 32'h00800000, "R2 maxden<minnorm");
      step(1, 32'h3F800000, 32'h80000005, "R2 B den");
      // R4 quiet NaN, R5 signalling NaN, R9 summary
      step(1, 32'h7FC00000, 32'h3F800000, "R4 qnan A");
      step(1, 32'h3F800000, 32'hFFC00001, "R4 qnan B");
      step(1, 32'h7FC00000, 32'h7FC00000, "R4 qnan both");
      step(1, 32'h7F800001, 32'h3F800000, "R5 snan A");
      step(1, 32'h00000001, 32'hFFA00000, "R5 snan B den A");
      step(1, 32'h7FC00000, 32'h7F800001, "R5 q+s");
      step(1, 32'h3F800000, 32'h3F800000, "R9 summary clears");
      step(0, 32'h0, 32'h0, "idle");
      // R7 / R10 random stream with gaps
      for (int i = 0; i < 400; i++) begin
         logic [31:0] ra, rb;
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         ra = lfsr;
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         rb = (i % 5 == 0) ? ra : (i % 7 == 0) ? {~ra[31], ra[30:0]} : lfsr;
         if (i % 11 == 0) rb[30:23] = 8'h00;
         if (i % 13 == 0) ra[30:23] = 8'hFF;
         step((i % 6) != 3, ra, rb, "R7 R10 random");
      end
      step(0, 32'h0, 32'h0, "idle");
      step(0, 32'h0, 32'h0, "idle");
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         failures++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule